// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulate Unit

This unit executes one custom instruction from a 32-bit instruction word. It takes two 32-bit operands and splits each into four byte lanes. It multiplies matching lanes as unsigned 8x8 values, adds the four products, and adds that total to the old value of the destination register. The destination register is therefore also the accumulator source.

The surrounding core reads the three operand values from its register file and presents them together with the instruction word and a valid strobe. The unit reports combinationally whether the word is its instruction. One clock later it returns the sum, the destination index, a result strobe and a write permission. Register file access and hazard handling stay with the caller.

Top module: `dotacc_unit`

## Requirements
- R1: `hitFlag` is combinational. It is high exactly when instruction bits [6:0] equal 1111011, bits [14:12] equal 001 and bits [31:25] equal 1001100. Every other bit of the word has no effect on it.
- R2: For an accepted instruction, `destIdx` reports instruction bits [11:7]. Bits [19:15] and [24:20] only name the source operands, and the caller supplies those operand values on `srcA` and `srcB`.
- R3: For an accepted instruction, `resultOut` equals `accIn` plus the four products `srcA` byte k times `srcB` byte k, for k = 0..3. Each product is taken as unsigned and zero-extended before it is added.
- R4: The sum wraps modulo 2^32. There is no saturation and no overflow indication.
- R5: No `resultValid` pulse follows a cycle where `inValid` is low or `hitFlag` is low. In that case `resultOut` and `destIdx` keep their previous values.
- R6: `resultValid`, `resultOut` and `destIdx` are registered. They update at the first rising edge after an accepted input, and back-to-back inputs give back-to-back results.
- R7: When `rstN` is low at a rising edge, that edge clears `resultValid`, `wrEn`, `resultOut` and `destIdx` to zero. Reset wins over a valid input in the same cycle.
- R8: `wrEn` is high exactly when `resultValid` is high and `destIdx` is non-zero. A result for destination 0 is still reported on `resultOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Instruction and operands are present |
| instrWord | input | 32 | Instruction word |
| srcA | input | 32 | First source operand value |
| srcB | input | 32 | Second source operand value |
| accIn | input | 32 | Old value of the destination register |
| hitFlag | output | 1 | Instruction word is the dot-product instruction |
| resultOut | output | 32 | Accumulated dot-product result |
| destIdx | output | 5 | Destination register index of the result |
| resultValid | output | 1 | Result strobe, one cycle after acceptance |
| wrEn | output | 1 | Register update permitted (destination non-zero) |

## Verification
The assertions assume that `rstN` is driven low before the first edge. They also assume that every input is stable around the rising edge, so the value sampled there is the value that was decoded. The stimulus meets both assumptions: it holds reset from time zero and changes inputs only on the falling edge. Decode checks flip every single instruction bit and sweep the whole opcode, funct3 and funct7 ranges. The arithmetic checks run a stepped grid of lane values, saturated lanes against a full accumulator, and random operands mixed with idle and non-matching cycles.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = XLEN / LANE_W;
  localparam int unsigned PROD_W    = 2 * LANE_W;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned RD_LSB    = 7;

  localparam logic [6:0] OPC_VAL = 7'b1111011;
  localparam logic [2:0] F3_VAL  = 3'b001;
  localparam logic [6:0] F7_VAL  = 7'b1001100;

  // Fixed-field mask and value: opcode [6:0], funct3 [14:12], funct7 [31:25]
  localparam logic [31:0] MATCH_MASK  = {7'h7F, 10'h000, 3'h7, 5'h00, 7'h7F};
  localparam logic [31:0] MATCH_VALUE = {F7_VAL, 10'h000, F3_VAL, 5'h00, OPC_VAL};

  typedef struct packed {
    logic capture;   // accepted instruction: load datapath registers
    logic destLive;  // destination index is non-zero
  } dotCtrl_t;
endpackage

// File: rtl/dotacc_ctrl.sv
module dotacc_ctrl
  import dotacc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  output logic        hitFlag,
  output dotCtrl_t    ctrl,
  output logic        resultValid,
  output logic        wrEn
);
  logic validQ;
  logic wrEnQ;

  assign hitFlag       = (instrWord & MATCH_MASK) == MATCH_VALUE;
  assign ctrl.capture  = inValid & hitFlag;
  assign ctrl.destLive = |instrWord[RD_LSB +: REG_IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      wrEnQ  <= 1'b0;
    end else begin
      validQ <= ctrl.capture;
      wrEnQ  <= ctrl.capture & ctrl.destLive;
    end
  end

  assign resultValid = validQ;
  assign wrEn        = wrEnQ;

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && hitFlag) |=> resultValid);

  assert_no_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && hitFlag) |=> !resultValid);
endmodule

// File: rtl/dotacc_datapath.sv
module dotacc_datapath
  import dotacc_pkg::*;
#(
  parameter int unsigned DATA_W  = XLEN,
  parameter int unsigned LANE_BW = LANE_W,
  parameter int unsigned IDX_W   = REG_IDX_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  dotCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accIn,
  input  logic [IDX_W-1:0]  destField,
  output logic [DATA_W-1:0] resultOut,
  output logic [IDX_W-1:0]  destIdx
);
  localparam int unsigned LANES = DATA_W / LANE_BW;
  localparam int unsigned PW    = 2 * LANE_BW;

  logic [PW-1:0]     laneProd [LANES];
  logic [DATA_W-1:0] dotSum;
  logic [DATA_W-1:0] nextResult;
  logic [DATA_W-1:0] resultQ;
  logic [IDX_W-1:0]  destQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneProd[g] = PW'(srcA[g*LANE_BW +: LANE_BW]) * PW'(srcB[g*LANE_BW +: LANE_BW]);
  end

  always_comb begin
    dotSum = '0;
    for (int i = 0; i < LANES; i++) begin
      dotSum = dotSum + DATA_W'(laneProd[i]);
    end
    nextResult = accIn + dotSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      destQ   <= '0;
    end else if (ctrl.capture) begin
      resultQ <= nextResult;
      destQ   <= destField;
    end
  end

  assign resultOut = resultQ;
  assign destIdx   = destQ;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(resultQ) && $stable(destQ)));

  assert_zero_lanes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && srcA == '0) |=> (resultQ == $past(accIn)));
endmodule

// File: rtl/dotacc_unit.sv
module dotacc_unit
  import dotacc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic [31:0] accIn,
  output logic        hitFlag,
  output logic [31:0] resultOut,
  output logic [4:0]  destIdx,
  output logic        resultValid,
  output logic        wrEn
);
  dotCtrl_t ctrl;

  dotacc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .hitFlag(hitFlag), .ctrl(ctrl), .resultValid(resultValid), .wrEn(wrEn)
  );

  dotacc_datapath #(.DATA_W(XLEN), .LANE_BW(LANE_W), .IDX_W(REG_IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB), .accIn(accIn),
    .destField(instrWord[RD_LSB +: REG_IDX_W]), .resultOut(resultOut), .destIdx(destIdx)
  );

  assert_wren_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (wrEn == (destIdx != 5'd0)));

  assert_wren_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> resultValid);
endmodule

// File: tb/dotacc_unit_tb_top.sv
module dotacc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] accIn = '0;
  logic        hitFlag;
  logic [31:0] resultOut;
  logic [4:0]  destIdx;
  logic        resultValid;
  logic        wrEn;

  int errors = 0;
  int checks = 0;
  logic [31:0] lastRes = '0;
  logic [4:0]  lastDest = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dotacc_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .srcA(srcA), .srcB(srcB), .accIn(accIn), .hitFlag(hitFlag),
    .resultOut(resultOut), .destIdx(destIdx), .resultValid(resultValid), .wrEn(wrEn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
    return {7'b1001100, rs2, rs1, 3'b001, rd, 7'b1111011};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc);
    longint unsigned s = acc;
    for (int k = 0; k < 4; k++) s += longint'(a[8*k +: 8]) * longint'(b[8*k +: 8]);
    return s[31:0];
  endfunction

  // Called at a falling edge; checks one cycle later at the next falling edge.
  task automatic step(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] acc, input logic v, input string req);
    logic expHit;
    logic expValid;
    instrWord = iw; srcA = a; srcB = b; accIn = acc; inValid = v;
    expHit = (iw[6:0] == 7'b1111011) && (iw[14:12] == 3'b001) && (iw[31:25] == 7'b1001100);
    #1;
    chk(hitFlag == expHit, "R1 hitFlag", {31'b0, hitFlag}, {31'b0, expHit});
    expValid = v && expHit;
    if (expValid) begin
      lastRes  = model(a, b, acc);
      lastDest = iw[11:7];
    end
    @(negedge clk);
    chk(resultValid == expValid, expValid ? "R6 resultValid" : "R5 resultValid",
        {31'b0, resultValid}, {31'b0, expValid});
    chk(resultOut == lastRes, req, resultOut, lastRes);
    chk(destIdx == lastDest, "R2 destIdx", {27'b0, destIdx}, {27'b0, lastDest});
    chk(wrEn == (expValid && lastDest != 0), "R8 wrEn", {31'b0, wrEn},
        {31'b0, (expValid && lastDest != 0)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    chk(resultValid == 0 && wrEn == 0, "R7 reset flags", {30'b0, resultValid, wrEn}, 32'h0);
    chk(resultOut == 0, "R7 reset result", resultOut, 32'h0);
    chk(destIdx == 0, "R7 reset dest", {27'b0, destIdx}, 32'h0);
    rstN = 1'b1;

    // Basic and zero-destination results
    step(mkInstr(5'd3, 5'd1, 5'd2), 32'h01020304, 32'h05060708, 32'd100, 1'b1, "R3 basic");
    step(mkInstr(5'd0, 5'd4, 5'd5), 32'h0A0B0C0D, 32'h01010101, 32'd7, 1'b1, "R8 dest zero value");
    step(mkInstr(5'd9, 5'd1, 5'd2), 32'h11111111, 32'h22222222, 32'd0, 1'b0, "R5 idle hold");
    // Wrap: saturated lanes into a full accumulator
    step(mkInstr(5'd31, 5'd7, 5'd8), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R4 wrap");
    step(mkInstr(5'd30, 5'd7, 5'd8), 32'hFF00FF00, 32'hFFFFFFFF, 32'hFFFF0000, 1'b1, "R4 wrap partial");

    // Single-bit flips of a matching word
    base = mkInstr(5'd12, 5'd13, 5'd14);
    for (int bitPos = 0; bitPos < 32; bitPos++)
      step(base ^ (32'h1 << bitPos), 32'h80402010, 32'h08040201, 32'h12345678, 1'b1, "R1 flip result");

    // Full opcode, funct3 and funct7 sweeps
    for (int v = 0; v < 128; v++)
      step({base[31:7], 7'(v)}, 32'(v * 977), 32'(v * 131), 32'(v), 1'b1, "R1 opcode sweep");
    for (int v = 0; v < 8; v++)
      step({base[31:15], 3'(v), base[11:0]}, 32'(v * 3001), 32'hFEDCBA98, 32'(v), 1'b1, "R1 funct3 sweep");
    for (int v = 0; v < 128; v++)
      step({7'(v), base[24:0]}, 32'(v * 4099), 32'h0F0F0F0F, 32'(v), 1'b1, "R1 funct7 sweep");

    // Stepped lane grid replicated across lanes, back-to-back
    for (int a = 0; a < 256; a += 15)
      for (int b = 0; b < 256; b += 15)
        step(mkInstr(5'((a + b) % 32), 5'd1, 5'd2), {4{8'(a)}}, {4{8'(b)}},
             32'(a * 65536 + b), 1'b1, "R3 lane grid");

    // Random operands with idle and non-matching cycles mixed in
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] iw;
      logic [31:0] r;
      r  = $urandom;
      iw = mkInstr(5'($urandom), 5'($urandom), 5'($urandom));
      if (r[2:0] == 3'd0) iw[13] = 1'b1;
      step(iw, $urandom, $urandom, $urandom, r[4:3] != 2'b00, "R3 random");
    end

    // Reset takes priority over an accepted input
    instrWord = mkInstr(5'd5, 5'd1, 5'd2); inValid = 1'b1; srcA = 32'h01010101;
    srcB = 32'h01010101; accIn = 32'd1; rstN = 1'b0;
    @(negedge clk);
    chk(resultValid == 0 && wrEn == 0, "R7 reset over valid", {30'b0, resultValid, wrEn}, 32'h0);
    chk(resultOut == 0, "R7 reset clears result", resultOut, 32'h0);
    chk(destIdx == 0, "R7 reset clears dest", {27'b0, destIdx}, 32'h0);
    rstN = 1'b1; inValid = 1'b0;
    lastRes = '0; lastDest = '0;
    step(mkInstr(5'd6, 5'd1, 5'd2), 32'h00000000, 32'hFFFFFFFF, 32'hCAFEF00D, 1'b1, "R3 zero lanes");
    step(mkInstr(5'd6, 5'd1, 5'd2), 32'h0, 32'h0, 32'h0, 1'b0, "R6 single pulse");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule